// File: doc/BRIEF.md
# PoE Event and Interrupt Register Bank

This block is the event and interrupt part of the register map of a four-port power-sourcing controller. Each port reports its events as one-cycle pulses: power-good change, power-enable change, classification done, detection done, disconnect, overcurrent cut, current limit and start fault. The supply monitor reports four flags: thermal shutdown, VDD undervoltage, VDD warning and VPWR undervoltage. Each pulse sets a sticky bit in one of five event bytes.

A host reaches the bank over a byte-wide register bus. `rd_data` follows `addr` combinationally. A read strobe at the odd address of an event pair returns the byte and clears it at the same clock edge. The bank condenses the event bytes into an interrupt summary byte. It gates that byte with a mask byte and a global enable, and drives the active-low `irq_n` pin.

The pin is controlled by a three-state machine:
- `PIN_IDLE`: the pin is released.
- `PIN_ACTIVE`: the pin is driven low.
- `PIN_MUTED`: the host has silenced the pin.

The transitions are:
- `PIN_IDLE` to `PIN_ACTIVE` when an unmasked interrupt is pending.
- `PIN_ACTIVE` to `PIN_IDLE` when nothing is pending.
- `PIN_IDLE` or `PIN_ACTIVE` to `PIN_MUTED` on the release command.
- `PIN_MUTED` to `PIN_IDLE` when some event bit goes from 0 to 1.

Top module: `poe_evt_irq_bank`

## Requirements
- R1: Reset values are as follows. The summary byte (00h) reads 80h. The mask (01h) reads 80h. The supply byte (0Ah) reads 70h. The enable byte (17h) reads 80h. All other event bytes read 00h. `irq_n` is high while in reset and falls one clock after reset is released, because supply flags are set.
- R2: A pulse sets a sticky bit in its byte. The bytes are:
  - 02h: power-good bits 7:4 and power-enable bits 3:0.
  - 04h: classification bits 7:4 and detection bits 3:0.
  - 06h: disconnect bits 7:4 and overcurrent-cut bits 3:0.
  - 08h: current-limit bits 7:4 and start-fault bits 3:0.
  - 0Ah: supply flags bits 7:4, where thermal is bit 7, VDD undervoltage bit 6, VDD warning bit 5 and VPWR undervoltage bit 4. Bits 3:0 of 0Ah read 0.
- R3: A read strobe at an even event address (02h, 04h, 06h, 08h, 0Ah) leaves the byte unchanged.
- R4: A read strobe at the odd twin address (03h, 05h, 07h, 09h, 0Bh) returns the same byte and clears it at that clock edge.
- R5: A pulse that arrives in the same cycle as a clearing read of its byte is still set afterwards.
- R6: Each bit of the summary byte is 1 when its source nibble is nonzero. The bit order, from bit 7 down to bit 0, is:
  - supply byte
  - start-fault
  - overcurrent-cut
  - classification
  - detection
  - disconnect
  - power-good
  - power-enable

  Current-limit bits do not feed the summary. Writes to 00h are ignored.
- R7: The mask at 01h is read/write and uses the same bit order as the summary byte. A 1 lets that summary bit drive the pin.
- R8: `irq_n` goes low two clocks after a pulse whose summary bit is unmasked, given that the enable bit is set. A masked pulse leaves `irq_n` high.
- R9: Bit 7 of 17h is the interrupt enable, and the other bits of 17h read 0. With the enable at 0, `irq_n` is high one clock after the write.
- R10: Writing 1Ah with bit 7 set clears all five event bytes, the supply byte included, to 00h.
- R11: Writing 1Ah with bit 6 set releases `irq_n` at once and keeps it high, even while pending bits remain. A pulse on a bit that is already set does not rearm the pin. A pulse that sets a new bit rearms it, and the pin falls two clocks later if an unmasked interrupt is still pending.
- R12: 1Ah reads 00h. Writes to read-only bytes (00h, 0Ah) are ignored. Unmapped addresses read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register address |
| rd_en | input | 1 | Read strobe; triggers clear at odd event addresses |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| pwr_good_evt | input | 4 | Power-good change pulses, one per port |
| pwr_en_evt | input | 4 | Power-enable change pulses |
| class_evt | input | 4 | Classification done pulses |
| det_evt | input | 4 | Detection done pulses |
| disc_evt | input | 4 | Disconnect pulses |
| icut_evt | input | 4 | Overcurrent-cut pulses |
| ilim_evt | input | 4 | Current-limit pulses |
| start_evt | input | 4 | Start fault pulses |
| supply_evt | input | 4 | Supply flag pulses {thermal, VDD UV, VDD warn, VPWR UV} |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest situation to reach is `PIN_MUTED` with pending interrupts still present, followed by a distinction between a pulse that re-sets an existing bit and a pulse that creates a new one. The stimulus first arms the pin with an unmasked power-enable event and then issues the release command. It then fires the same power-enable bit again, which must not wake the pin. Finally it fires a masked detection bit, which must wake the pin only because the earlier event is still pending. The coincident clear-and-set case is reached by driving the pulse in the very cycle that the odd-address read strobe is high.

// File: rtl/poe_evt_pkg.sv
package poe_evt_pkg;
    localparam logic [7:0] ADR_SUMMARY  = 8'h00;
    localparam logic [7:0] ADR_MASK     = 8'h01;
    localparam logic [7:0] ADR_EVT_BASE = 8'h02;
    localparam logic [7:0] ADR_ENABLE   = 8'h17;
    localparam logic [7:0] ADR_COMMAND  = 8'h1A;

    localparam int CMD_CLEAR_ALL_BIT = 7;
    localparam int CMD_RELEASE_BIT   = 6;
    localparam int ENABLE_BIT        = 7;

    // event byte slots, address order
    localparam int SLOT_POWER  = 0;
    localparam int SLOT_DETECT = 1;
    localparam int SLOT_FAULT  = 2;
    localparam int SLOT_START  = 3;
    localparam int SLOT_SUPPLY = 4;
    localparam int NUM_SLOTS   = 5;

    typedef enum logic [1:0] {
        PIN_IDLE   = 2'd0,
        PIN_ACTIVE = 2'd1,
        PIN_MUTED  = 2'd2
    } pin_state_e;

    function automatic logic [7:0] slot_addr(input int slot);
        return ADR_EVT_BASE + 8'(2 * slot);
    endfunction
endpackage

// File: rtl/poe_evt_latch.sv
module poe_evt_latch #(
    parameter int              W       = 8,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] q_o,
    output logic         fresh_o
);
    // a set in the clearing cycle survives the clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q_o <= RST_VAL;
        else if (clr_i) q_o <= set_i;
        else            q_o <= q_o | set_i;
    end

    assign fresh_o = |(set_i & ~q_o);
endmodule

// File: rtl/poe_irq_pin_fsm.sv
module poe_irq_pin_fsm
    import poe_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    input  logic release_i,
    input  logic fresh_i,
    output logic irq_n_o
);
    pin_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_IDLE: begin
                if (release_i)      state_d = PIN_MUTED;
                else if (pending_i) state_d = PIN_ACTIVE;
            end
            PIN_ACTIVE: begin
                if (release_i)       state_d = PIN_MUTED;
                else if (!pending_i) state_d = PIN_IDLE;
            end
            PIN_MUTED: begin
                if (!release_i && fresh_i) state_d = PIN_IDLE;
            end
            default: state_d = PIN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PIN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_n_o = (state_q != PIN_ACTIVE);
    end
endmodule

// File: rtl/poe_evt_irq_bank.sv
module poe_evt_irq_bank
    import poe_evt_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int NSUP  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       addr,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data,
    input  logic [NPORT-1:0] pwr_good_evt,
    input  logic [NPORT-1:0] pwr_en_evt,
    input  logic [NPORT-1:0] class_evt,
    input  logic [NPORT-1:0] det_evt,
    input  logic [NPORT-1:0] disc_evt,
    input  logic [NPORT-1:0] icut_evt,
    input  logic [NPORT-1:0] ilim_evt,
    input  logic [NPORT-1:0] start_evt,
    input  logic [NSUP-1:0]  supply_evt,
    output logic             irq_n
);
    localparam int DW = 2 * NPORT;
    localparam logic [NSUP-1:0] SUP_FLAGS_RST = NSUP'(4'b0111);
    localparam logic [DW-1:0]   SUP_BYTE_RST  = {SUP_FLAGS_RST, {(DW-NSUP){1'b0}}};
    localparam logic [DW-1:0]   SUMMARY_RST   = DW'(8'h80);

    logic [DW-1:0]           evt_set  [NUM_SLOTS];
    logic [DW-1:0]           evt_q    [NUM_SLOTS];
    logic [NUM_SLOTS-1:0]    fresh_vec;
    logic [NUM_SLOTS*DW-1:0] evt_flat;
    logic [DW-1:0]           mask_q;
    logic                    int_en_q;
    logic [DW-1:0]           summary;
    logic                    cmd_wr, clear_all, release_pin, pending;

    assign evt_set[SLOT_POWER]  = {pwr_good_evt, pwr_en_evt};
    assign evt_set[SLOT_DETECT] = {class_evt, det_evt};
    assign evt_set[SLOT_FAULT]  = {disc_evt, icut_evt};
    assign evt_set[SLOT_START]  = {ilim_evt, start_evt};
    assign evt_set[SLOT_SUPPLY] = {supply_evt, {(DW-NSUP){1'b0}}};

    assign cmd_wr      = wr_en && (addr == ADR_COMMAND);
    assign clear_all   = cmd_wr && wr_data[CMD_CLEAR_ALL_BIT];
    assign release_pin = cmd_wr && wr_data[CMD_RELEASE_BIT];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic rd_clear;
        assign rd_clear = rd_en && (addr == slot_addr(g) + 8'd1);
        poe_evt_latch #(
            .W       (DW),
            .RST_VAL ((g == SLOT_SUPPLY) ? SUP_BYTE_RST : '0)
        ) u_latch (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (evt_set[g]),
            .clr_i   (clear_all | rd_clear),
            .q_o     (evt_q[g]),
            .fresh_o (fresh_vec[g])
        );
        assign evt_flat[g*DW +: DW] = evt_q[g];
    end

    // summary: one bit per nonzero source nibble; current-limit excluded
    assign summary = {
        |evt_q[SLOT_SUPPLY],
        |evt_q[SLOT_START][NPORT-1:0],
        |evt_q[SLOT_FAULT][NPORT-1:0],
        |evt_q[SLOT_DETECT][DW-1:NPORT],
        |evt_q[SLOT_DETECT][NPORT-1:0],
        |evt_q[SLOT_FAULT][DW-1:NPORT],
        |evt_q[SLOT_POWER][DW-1:NPORT],
        |evt_q[SLOT_POWER][NPORT-1:0]
    };

    assign pending = int_en_q && |(summary & mask_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q   <= SUMMARY_RST;
            int_en_q <= 1'b1;
        end else if (wr_en) begin
            if (addr == ADR_MASK)   mask_q   <= wr_data;
            if (addr == ADR_ENABLE) int_en_q <= wr_data[ENABLE_BIT];
        end
    end

    always_comb begin
        rd_data = '0;
        if (addr == ADR_SUMMARY)     rd_data = summary;
        else if (addr == ADR_MASK)   rd_data = mask_q;
        else if (addr == ADR_ENABLE) rd_data = {int_en_q, 7'b0};
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if ({addr[7:1], 1'b0} == slot_addr(i)) rd_data = evt_q[i];
        end
    end

    poe_irq_pin_fsm u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (pending),
        .release_i (release_pin),
        .fresh_i   (|fresh_vec),
        .irq_n_o   (irq_n)
    );
endmodule

// File: rtl/poe_evt_checks.sv
module poe_evt_checks (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  addr,
    input logic        rd_en,
    input logic        wr_en,
    input logic [7:0]  wr_data,
    input logic [7:0]  rd_data,
    input logic [3:0]  pwr_good_evt,
    input logic [3:0]  pwr_en_evt,
    input logic        irq_n,
    input logic        int_en_q,
    input logic [39:0] evt_flat
);
    assert_pulse_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_en_evt[0] |=> evt_flat[0]);

    assert_even_read_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 8'h02 && pwr_good_evt == 4'h0 && pwr_en_evt == 4'h0
         && !(wr_en && addr == 8'h1A)) |=> $stable(evt_flat[7:0]));

    assert_odd_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 8'h03 && pwr_good_evt == 4'h0 && pwr_en_evt == 4'h0)
        |=> evt_flat[7:0] == 8'h00);

    assert_coincident_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 8'h03 && pwr_en_evt[1]) |=> evt_flat[1]);

    assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_en_q && $past(!int_en_q)) |-> irq_n);

    assert_release_mutes_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h1A && wr_data[6]) |=> irq_n);

    assert_cmd_reads_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 8'h1A) |-> rd_data == 8'h00);
endmodule

bind poe_evt_irq_bank poe_evt_checks u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr         (addr),
    .rd_en        (rd_en),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .pwr_good_evt (pwr_good_evt),
    .pwr_en_evt   (pwr_en_evt),
    .irq_n        (irq_n),
    .int_en_q     (int_en_q),
    .evt_flat     (evt_flat)
);

// File: tb/poe_evt_irq_bank_test.sv
`timescale 1ns/1ps
module poe_evt_irq_bank_test;
    localparam time HALF = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [3:0] pg = '0, pe = '0, cl = '0, dt = '0;
    logic [3:0] ds = '0, ic = '0, il = '0, st = '0, sp = '0;
    logic       irq_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #HALF clk = ~clk;

    poe_evt_irq_bank uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data),
        .pwr_good_evt(pg), .pwr_en_evt(pe), .class_evt(cl), .det_evt(dt),
        .disc_evt(ds), .icut_evt(ic), .ilim_evt(il), .start_evt(st),
        .supply_evt(sp), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0; addr = 8'hFF;
        #1;
    endtask

    task automatic expect_rd(input string req, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] d;
        reg_rd(a, d);
        check(req, d, exp);
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; addr = 8'hFF;
        #1;
    endtask

    task automatic drive_evt(input int kind, input logic [3:0] b);
        case (kind)
            0: pg = b;  1: pe = b;  2: cl = b;  3: dt = b;  4: ds = b;
            5: ic = b;  6: il = b;  7: st = b;  default: sp = b;
        endcase
    endtask

    task automatic fire(input int kind, input logic [3:0] b);
        drive_evt(kind, b);
        @(negedge clk);
        drive_evt(kind, 4'h0);
        #1;
    endtask

    task automatic t_reset;
        check("R1 summary", rd_data, 8'h00); // addr FF not yet set
        addr = 8'h00; #1 check("R1 summary rst", rd_data, 8'h80);
        addr = 8'h01; #1 check("R1 mask rst", rd_data, 8'h80);
        addr = 8'h0A; #1 check("R1 supply rst", rd_data, 8'h70);
        addr = 8'h17; #1 check("R1 enable rst", rd_data, 8'h80);
        addr = 8'h02; #1 check("R1 power rst", rd_data, 8'h00);
        check("R1 pin in reset", {7'b0, irq_n}, 8'h01);
        addr = 8'hFF;
        @(negedge clk); rst_n = 1'b1; #1;
        check("R1 pin at release", {7'b0, irq_n}, 8'h01);
        tick(1);
        check("R1 pin after release", {7'b0, irq_n}, 8'h00);
        expect_rd("R4 supply clr-read", 8'h0B, 8'h70);
        expect_rd("R4 supply cleared", 8'h0A, 8'h00);
        tick(1);
        check("R8 pin idle after clear", {7'b0, irq_n}, 8'h01);
    endtask

    task automatic t_layout;
        fire(0, 4'b0100); fire(1, 4'b0001);
        fire(2, 4'b0010); fire(3, 4'b1000);
        fire(4, 4'b0001); fire(5, 4'b1000);
        fire(6, 4'b1000); fire(7, 4'b0010);
        fire(8, 4'b1001);
        expect_rd("R2 power byte", 8'h02, 8'h41);
        expect_rd("R3 power byte kept", 8'h02, 8'h41);
        expect_rd("R2 detect byte", 8'h04, 8'h28);
        expect_rd("R2 fault byte", 8'h06, 8'h18);
        expect_rd("R2 start byte", 8'h08, 8'h82);
        expect_rd("R2 supply byte", 8'h0A, 8'h90);
        expect_rd("R6 summary all", 8'h00, 8'hFF);
        expect_rd("R4 power clr-read", 8'h03, 8'h41);
        expect_rd("R4 power cleared", 8'h02, 8'h00);
        expect_rd("R6 summary low bits", 8'h00, 8'hFC);
        expect_rd("R4 start clr-read", 8'h09, 8'h82);
        expect_rd("R6 summary start gone", 8'h00, 8'hBC);
        fire(6, 4'b0001);
        expect_rd("R6 ilim latched", 8'h08, 8'h10);
        expect_rd("R6 ilim not summarised", 8'h00, 8'hBC);
        reg_wr(8'h1A, 8'h80);
        expect_rd("R10 power zero", 8'h02, 8'h00);
        expect_rd("R10 detect zero", 8'h04, 8'h00);
        expect_rd("R10 fault zero", 8'h06, 8'h00);
        expect_rd("R10 start zero", 8'h08, 8'h00);
        expect_rd("R10 supply zero", 8'h0A, 8'h00);
        expect_rd("R10 summary zero", 8'h00, 8'h00);
    endtask

    task automatic t_coincident;
        logic [7:0] d;
        fire(0, 4'b0001);
        addr = 8'h03; rd_en = 1'b1; pe = 4'b0010;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0; pe = 4'h0; addr = 8'hFF; #1;
        check("R5 value before clear", d, 8'h10);
        expect_rd("R5 pulse survives", 8'h02, 8'h02);
        expect_rd("R4 tidy", 8'h03, 8'h02);
    endtask

    task automatic t_mask_enable;
        reg_wr(8'h01, 8'h01);
        expect_rd("R7 mask readback", 8'h01, 8'h01);
        fire(3, 4'b0001);
        tick(2);
        check("R8 masked keeps pin", {7'b0, irq_n}, 8'h01);
        fire(1, 4'b0001);
        check("R8 latency one clock", {7'b0, irq_n}, 8'h01);
        tick(1);
        check("R8 unmasked asserts", {7'b0, irq_n}, 8'h00);
        reg_wr(8'h17, 8'h00);
        tick(1);
        check("R9 disabled pin", {7'b0, irq_n}, 8'h01);
        expect_rd("R9 enable readback", 8'h17, 8'h00);
        reg_wr(8'h17, 8'hFF);
        expect_rd("R9 other bits zero", 8'h17, 8'h80);
        check("R9 re-enabled pin", {7'b0, irq_n}, 8'h00);
    endtask

    task automatic t_release;
        reg_wr(8'h1A, 8'h40);
        check("R11 released at once", {7'b0, irq_n}, 8'h01);
        tick(3);
        check("R11 stays released", {7'b0, irq_n}, 8'h01);
        expect_rd("R11 events kept", 8'h02, 8'h01);
        fire(1, 4'b0001);
        tick(2);
        check("R11 old bit no rearm", {7'b0, irq_n}, 8'h01);
        fire(3, 4'b0010);
        tick(1);
        check("R11 new bit rearms", {7'b0, irq_n}, 8'h00);
    endtask

    task automatic t_readonly;
        reg_wr(8'h00, 8'h00);
        expect_rd("R12 summary write ignored", 8'h00, 8'h09);
        fire(8, 4'b1000);
        reg_wr(8'h0A, 8'h00);
        expect_rd("R12 supply write ignored", 8'h0A, 8'h80);
        reg_wr(8'h1A, 8'h3F);
        expect_rd("R12 command reads zero", 8'h1A, 8'h00);
        expect_rd("R12 unmapped zero", 8'h50, 8'h00);
    endtask

    initial begin
        addr = 8'hFF;
        #1;
        tick(2);
        t_reset();
        t_layout();
        t_coincident();
        t_mask_enable();
        t_release();
        t_readonly();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule